// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo PCM audio from a three-wire serial port: a shift clock, a left/right frame clock and a data line. It accepts right-justified words of 16, 20 or 24 bits, I2S words of 16, 20 or 24 bits, and left-justified or DSP-framed words of 16 bits. A 3-bit mode input selects the format at run time. All logic runs on a system clock that oversamples the serial clocks. The shift clock runs at 64 slots per frame, which gives 32 slots per channel. Once per frame the block delivers a left and a right sample together with a one-clock valid strobe. Each sample is MSB-aligned in a 24-bit two's-complement word.

The three serial inputs pass through two-flop synchronizers. The rising edges of the shift clock are found in the system clock domain, and one data bit and one frame-clock level are taken at each such edge. A control state machine has four states. ST_HUNT waits for a frame start. ST_LEFT takes in the left word and ST_RIGHT the right word. ST_EMIT lasts one cycle and hands both words to the outputs.

The named transitions are:
- T_START (ST_HUNT to ST_LEFT): a falling frame clock, or in DSP mode the frame pulse.
- T_SWAP (ST_LEFT to ST_RIGHT): a rising frame clock, or in DSP mode the 16th data slot.
- T_DONE (ST_RIGHT to ST_EMIT): the final slot of the right half.
- T_RESYNC (ST_RIGHT to ST_LEFT): an early falling frame clock in the non-DSP formats.
- T_BACK (ST_EMIT to ST_HUNT): taken unconditionally.
- T_ABORT (any state to ST_HUNT): the mode input has changed.

A mode change also pulses a reset request output for the surrounding system.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and in the first cycles after its release, before any serial activity: sample_valid and reset_req are 0, and left_sample and right_sample are 0.
- R2: mode_sel 000, 001 and 010 select right-justified framing with 16, 20 and 24-bit words. The LSB sits in slot 31 of each 32-slot half and the MSB in slot 32-W. Slot 0 is the first shift-clock rising edge that sees the new frame-clock level, and a low frame clock marks the left half.
- R3: mode_sel 011, 100 and 101 select I2S framing with 16, 20 and 24-bit words. The MSB sits in slot 1 of each half.
- R4: mode_sel 110 selects left-justified 16-bit framing. The MSB sits in slot 0 of each half.
- R5: mode_sel 111 selects DSP framing. The frame clock is high for one slot as a frame pulse. The 16-bit left word follows in the next 16 slots, MSB first, and the 16-bit right word follows directly after it.
- R6: Each W-bit word appears with its MSB in bit 23 and zeros in bits 23-W down to 0. Data-line bits in slots outside the word are ignored.
- R7: sample_valid is high for exactly one clock per frame, and both samples update in that same cycle. It rises on the fourth system-clock rising edge after the shift-clock rising edge that carries the final slot of the right word (slot 31 of the right half, or the 32nd data slot in DSP mode). The samples hold their values between strobes.
- R8: reset_req is high for one clock, one system clock after mode_sel differs from its value in the previous cycle. The value present when reset is released raises no request.
- R9: A mode change during a frame abandons that frame, so no strobe follows for it. The receiver then waits for a fresh frame start in the new mode.
- R10: If the mode changes in the cycle in which a completed frame is being handed over, that frame is still delivered in the old format. sample_valid and reset_req are then high in the same cycle, and the next frame is taken in the new format.
- R11: No strobe is produced before the first frame start after reset or after a mode change, even while the shift clock toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Serial shift clock, 64 periods per frame |
| lrclk_in | input | 1 | Frame clock; low = left half (DSP: frame pulse) |
| sdata_in | input | 1 | Serial data, changes on shift-clock falling edges |
| mode_sel | input | 3 | Framing select, bit 2 is the MSB (see R2 to R5) |
| left_sample | output | 24 | Left sample, MSB-aligned |
| right_sample | output | 24 | Right sample, MSB-aligned |
| sample_valid | output | 1 | One-clock strobe when both samples update |
| reset_req | output | 1 | One-clock request raised by a mode change |

## Verification
The hand-over of a finished frame and the detection of a mode change can fall in the same system clock. The bench provokes this by driving the final shift-clock rising edge of an I2S frame and then changing mode_sel exactly three clocks later. That moves the detected change into the one cycle the state machine spends in ST_EMIT. The bench judges the outcome on the next clock: sample_valid and reset_req must both be high, the samples must hold the old format's words, and the next frame must then decode in the new left-justified format.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SLOTS_PER_HALF = 32;
    localparam int MAX_WORD_BITS  = 24;

    typedef enum logic [2:0] {
        FMT_RJ16  = 3'd0,
        FMT_RJ20  = 3'd1,
        FMT_RJ24  = 3'd2,
        FMT_I2S16 = 3'd3,
        FMT_I2S20 = 3'd4,
        FMT_I2S24 = 3'd5,
        FMT_LJ16  = 3'd6,
        FMT_DSP16 = 3'd7
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2,
        ST_EMIT  = 2'd3
    } rx_state_e;

    // word length in bits for a format
    function automatic int fmt_bits(fmt_e f);
        case (f)
            FMT_RJ20, FMT_I2S20: return 20;
            FMT_RJ24, FMT_I2S24: return 24;
            default:             return 16;
        endcase
    endfunction

    // slot of the MSB inside a channel half
    function automatic int fmt_first(fmt_e f);
        case (f)
            FMT_RJ16, FMT_RJ20, FMT_RJ24:    return SLOTS_PER_HALF - fmt_bits(f);
            FMT_I2S16, FMT_I2S20, FMT_I2S24: return 1;
            default:                         return 0;
        endcase
    endfunction

    function automatic logic fmt_is_dsp(fmt_e f);
        return f == FMT_DSP16;
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sar_slot_tracker.sv
module sar_slot_tracker #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             lr_s,
    input  logic             is_dsp,
    output logic             tick,
    output logic             lr_rose,
    output logic             lr_fell,
    output logic [CNT_W-1:0] slot_idx
);

    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    logic             sclk_prev;
    logic             lr_slot;
    logic [CNT_W-1:0] cnt;

    assign tick    = sclk_s & ~sclk_prev;
    assign lr_rose = tick & lr_s & ~lr_slot;
    assign lr_fell = tick & ~lr_s & lr_slot;

    // non-DSP: a frame-clock change marks slot 0; DSP: the running count
    always_comb begin
        if (!is_dsp && (lr_rose || lr_fell)) slot_idx = '0;
        else                                 slot_idx = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            lr_slot   <= 1'b0;
            cnt       <= IDX_MAX;
        end else begin
            sclk_prev <= sclk_s;
            if (tick) begin
                lr_slot <= lr_s;
                if (is_dsp && lr_rose)      cnt <= '0;
                else if (slot_idx != IDX_MAX) cnt <= slot_idx + CNT_W'(1);
                else                        cnt <= slot_idx;
            end
        end
    end

    // R7: a shift-clock edge yields a single-cycle event
    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sar_capture.sv
module sar_capture
    import sar_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_e                fmt,
    input  logic                tick,
    input  logic                cap_en,
    input  logic                lr_now,
    input  logic                sd_now,
    input  logic [CNT_W-1:0]    slot_idx,
    output logic                last_slot,
    output logic                half_done,
    output logic [SAMPLE_W-1:0] aligned_l,
    output logic [SAMPLE_W-1:0] aligned_r
);

    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(SLOTS_PER_HALF - 1);
    localparam logic [CNT_W-1:0] DSP_SPLIT = CNT_W'(SLOTS_PER_HALF / 2);
    localparam logic [CNT_W-1:0] DSP_HALF  = CNT_W'(SLOTS_PER_HALF / 2 - 1);

    logic                is_dsp;
    logic                ch_right;
    logic                in_word;
    int                  bits_i;
    int                  base_i;
    int                  rel;
    logic [SAMPLE_W-1:0] sh_l;
    logic [SAMPLE_W-1:0] sh_r;

    assign is_dsp = fmt_is_dsp(fmt);

    always_comb begin
        bits_i = fmt_bits(fmt);
        if (is_dsp) begin
            ch_right = slot_idx >= DSP_SPLIT;
            base_i   = ch_right ? (SLOTS_PER_HALF / 2) : 0;
        end else begin
            ch_right = lr_now;
            base_i   = fmt_first(fmt);
        end
        rel     = int'(slot_idx) - base_i;
        in_word = (rel >= 0) && (rel < bits_i);
    end

    assign last_slot = tick && cap_en && ch_right && (slot_idx == LAST_IDX);
    assign half_done = tick && cap_en && is_dsp && (slot_idx == DSP_HALF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_l <= '0;
            sh_r <= '0;
        end else if (tick && cap_en && in_word) begin
            if (ch_right) sh_r <= {sh_r[SAMPLE_W-2:0], sd_now};
            else          sh_l <= {sh_l[SAMPLE_W-2:0], sd_now};
        end
    end

    // the word sits in the low bits; move its MSB to the top, zero below
    always_comb begin
        aligned_l = sh_l << (SAMPLE_W - bits_i);
        aligned_r = sh_r << (SAMPLE_W - bits_i);
    end

    // R5: DSP capture never runs past the 32 data slots of a frame
    p_dsp_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cap_en && is_dsp) |-> (slot_idx <= LAST_IDX));

endmodule

// File: rtl/sar_mode_watch.sv
module sar_mode_watch
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_in,
    output fmt_e       fmt,
    output logic       mode_change,
    output logic       reset_req
);

    logic       primed;
    logic [2:0] mode_q;

    assign fmt         = fmt_e'(mode_q);
    assign mode_change = primed && (mode_in != mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed    <= 1'b0;
            mode_q    <= '0;
            reset_req <= 1'b0;
        end else begin
            primed    <= 1'b1;
            mode_q    <= mode_in;
            reset_req <= mode_change;
        end
    end

    // R8: the held format only moves together with a request
    p_fmt_move_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> (reset_req || $stable(mode_q)));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SAMPLE_W    = MAX_WORD_BITS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    input  logic [2:0]          mode_sel,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                sample_valid,
    output logic                reset_req
);

    localparam int CNT_W = $clog2(2 * SLOTS_PER_HALF);

    logic [2:0]          sync_q;
    logic                sclk_s, lr_s, sd_s;
    fmt_e                fmt;
    logic                mode_change;
    logic                is_dsp;
    logic                tick, lr_rose, lr_fell;
    logic [CNT_W-1:0]    slot_idx;
    logic                cap_en;
    logic                last_slot, half_done;
    logic                start_evt;
    logic [SAMPLE_W-1:0] aligned_l, aligned_r;
    rx_state_e           state_q, state_d;

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, lrclk_in, sdata_in}),
        .q     (sync_q)
    );
    assign {sclk_s, lr_s, sd_s} = sync_q;

    sar_mode_watch u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_in     (mode_sel),
        .fmt         (fmt),
        .mode_change (mode_change),
        .reset_req   (reset_req)
    );

    assign is_dsp = fmt_is_dsp(fmt);

    sar_slot_tracker #(.CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .lr_s     (lr_s),
        .is_dsp   (is_dsp),
        .tick     (tick),
        .lr_rose  (lr_rose),
        .lr_fell  (lr_fell),
        .slot_idx (slot_idx)
    );

    sar_capture #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .tick      (tick),
        .cap_en    (cap_en),
        .lr_now    (lr_s),
        .sd_now    (sd_s),
        .slot_idx  (slot_idx),
        .last_slot (last_slot),
        .half_done (half_done),
        .aligned_l (aligned_l),
        .aligned_r (aligned_r)
    );

    assign start_evt = is_dsp ? lr_rose : lr_fell;

    // capture in the word states, and on the slot-0 edge that ends a hunt
    assign cap_en = (state_q == ST_LEFT) || (state_q == ST_RIGHT) ||
                    ((state_q == ST_HUNT) && !is_dsp && lr_fell);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (start_evt) state_d = ST_LEFT;                   // T_START
            end
            ST_LEFT: begin
                if (!is_dsp && lr_rose)     state_d = ST_RIGHT;     // T_SWAP
                else if (is_dsp && half_done) state_d = ST_RIGHT;   // T_SWAP
            end
            ST_RIGHT: begin
                if (last_slot)              state_d = ST_EMIT;      // T_DONE
                else if (!is_dsp && lr_fell) state_d = ST_LEFT;     // T_RESYNC
            end
            ST_EMIT: begin
                state_d = ST_HUNT;                                  // T_BACK
            end
            default: state_d = ST_HUNT;
        endcase
        if (mode_change) state_d = ST_HUNT;                         // T_ABORT
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_sample  <= '0;
            right_sample <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= (state_q == ST_EMIT);
            if (state_q == ST_EMIT) begin
                left_sample  <= aligned_l;
                right_sample <= aligned_r;
            end
        end
    end

    // R9: a request always finds the machine hunting
    p_req_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (state_q == ST_HUNT));

    // R7: one strobe per hand-over
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7: hand-over only follows a shift-clock edge
    p_emit_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT) |-> $past(tick));

    // R7: samples hold between strobes
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_sample) && $stable(right_sample)));

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [23:0] left_sample, right_sample;
    logic        sample_valid, reset_req;

    int checks = 0;
    int failures = 0;
    int vcount = 0;
    int rcount = 0;
    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;

    serial_audio_rx i_serial_audio_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_in      (sclk),
        .lrclk_in     (lrclk),
        .sdata_in     (sdata),
        .mode_sel     (mode),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .sample_valid (sample_valid),
        .reset_req    (reset_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (sample_valid) begin
                vcount++;
                last_l = left_sample;
                last_r = right_sample;
            end
            if (reset_req) rcount++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int wl(int m);
        case (m)
            1, 4:    return 20;
            2, 5:    return 24;
            default: return 16;
        endcase
    endfunction

    function automatic int fs(int m);
        if (m <= 2) return 32 - wl(m);
        if (m <= 5) return 1;
        return 0;
    endfunction

    function automatic int last_slot_of(int m);
        return (m == 7) ? 32 : 63;
    endfunction

    function automatic logic lr_of(int m, int s);
        if (m == 7) return s == 0;
        return s >= 32;
    endfunction

    function automatic logic bit_of(int m, int s, logic [23:0] l, logic [23:0] r, logic junk);
        int w;
        int rel;
        logic [23:0] word;
        w = wl(m);
        if (m == 7) begin
            if (s >= 1 && s <= 16)  return l[16-s];
            if (s >= 17 && s <= 32) return r[32-s];
            return junk;
        end
        rel  = (s % 32) - fs(m);
        word = (s >= 32) ? r : l;
        if (rel >= 0 && rel < w) return word[w-1-rel];
        return junk;
    endfunction

    function automatic logic [23:0] expv(logic [23:0] v, int m);
        logic [23:0] msk;
        msk = (24'd1 << wl(m)) - 24'd1;
        return (v & msk) << (24 - wl(m));
    endfunction

    function automatic string tag_of(int m);
        if (m <= 2) return "R2";
        if (m <= 5) return "R3";
        if (m == 6) return "R4";
        return "R5";
    endfunction

    // one slot: low phase with new data, then rising edge; returns 3 clocks into high phase
    task automatic slot(input logic lr, input logic d);
        @(negedge clk);
        sclk  = 1'b0;
        lrclk = lr;
        sdata = d;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic preamble(input int m);
        for (int i = 0; i < 3; i++) slot((m == 7) ? 1'b0 : 1'b1, 1'($urandom()));
    endtask

    // kind 0: plain; 1: latency check; 2: latency check plus mode change in the hand-over cycle
    task automatic send_frame(input int m, input logic [23:0] l, input logic [23:0] r,
                              input int kind, input int newm);
        int v0;
        logic [23:0] el, er, lowmask;
        v0 = vcount;
        for (int s = 0; s < 64; s++) begin
            slot(lr_of(m, s), bit_of(m, s, l, r, 1'($urandom())));
            if (kind != 0 && s == last_slot_of(m)) begin
                chk(sample_valid == 1'b0, "R7 strobe early", 32'(sample_valid), 32'd0);
                if (kind == 2) mode = 3'(newm);
                @(negedge clk);
                chk(sample_valid == 1'b1, "R7 strobe latency", 32'(sample_valid), 32'd1);
                if (kind == 2) begin
                    chk(reset_req == 1'b1, "R10 request with strobe", 32'(reset_req), 32'd1);
                    chk(left_sample == expv(l, m), "R10 old format left", 32'(left_sample), 32'(expv(l, m)));
                end
            end
        end
        repeat (12) @(negedge clk);
        el = expv(l, m);
        er = expv(r, m);
        lowmask = (24'd1 << (24 - wl(m))) - 24'd1;
        chk(vcount == v0 + 1, "R7 one strobe per frame", 32'(vcount - v0), 32'd1);
        chk(last_l == el, {tag_of(m), " left"}, 32'(last_l), 32'(el));
        chk(last_r == er, {tag_of(m), " right"}, 32'(last_r), 32'(er));
        chk((last_l & lowmask) == 24'd0 && (last_r & lowmask) == 24'd0,
            "R6 low bits zero", 32'(last_l & lowmask), 32'd0);
    endtask

    task automatic change_mode(input int m);
        @(negedge clk);
        mode = 3'(m);
        @(negedge clk);
        chk(reset_req == 1'b1, "R8 request raised", 32'(reset_req), 32'd1);
        @(negedge clk);
        chk(reset_req == 1'b0, "R8 request one cycle", 32'(reset_req), 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R7 watchdog expired act=%0d exp=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v0;
        int w;
        logic [23:0] a, b;
        void'($urandom(32'd24601));
        mode  = 3'd0;
        lrclk = 1'b1;
        repeat (5) @(negedge clk);
        chk(sample_valid == 1'b0 && reset_req == 1'b0, "R1 flags in reset",
            32'({sample_valid, reset_req}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sample_valid == 1'b0, "R1 valid after reset", 32'(sample_valid), 32'd0);
        chk(left_sample == 24'd0 && right_sample == 24'd0, "R1 samples zero",
            32'(left_sample | right_sample), 32'd0);
        chk(rcount == 0, "R8 no request for initial mode", 32'(rcount), 32'd0);

        for (int m = 0; m < 8; m++) begin
            if (m > 0) change_mode(m);
            v0 = vcount;
            preamble(m);
            chk(vcount == v0, "R11 no strobe before frame start", 32'(vcount - v0), 32'd0);
            w = wl(m);
            send_frame(m, 24'hFFFFFF, 24'h000000, 0, 0);
            send_frame(m, 24'(1 << (w - 1)), 24'((1 << (w - 1)) - 1), 0, 0);
            for (int k = 0; k < 4; k++) begin
                a = 24'($urandom());
                b = 24'($urandom());
                send_frame(m, a, b, (k == 0) ? 1 : 0, 0);
            end
        end

        // R9: abandon a DSP frame midway, then decode I2S24
        for (int s = 0; s < 21; s++) slot(lr_of(7, s), 1'($urandom()));
        v0 = vcount;
        change_mode(5);
        preamble(5);
        repeat (12) @(negedge clk);
        chk(vcount == v0, "R9 abandoned frame not delivered", 32'(vcount - v0), 32'd0);
        a = 24'($urandom());
        b = 24'($urandom());
        send_frame(5, a, b, 0, 0);
        chk(vcount == v0 + 1, "R9 new mode decodes", 32'(vcount - v0), 32'd1);

        // R10: mode change lands in the hand-over cycle
        v0 = rcount;
        a = 24'($urandom());
        b = 24'($urandom());
        send_frame(5, a, b, 2, 6);
        chk(rcount == v0 + 1, "R10 single request", 32'(rcount - v0), 32'd1);
        preamble(6);
        a = 24'($urandom());
        b = 24'($urandom());
        send_frame(6, a, b, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule